// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine and keeps the coherence directory for the cache lines that live in that node's memory. Each line has an entry with a state, a vector of sharer nodes and an owner node number. The state is one of three: nobody caches the line, one or more nodes hold clean copies, or one node holds a modified copy. Remote nodes send three kinds of request: a read, a read for ownership (exclusive), and a notice that they have modified a copy they already hold.

For each request the controller picks one action. It can answer at once from home memory. It can send the request on to the node that owns a dirty copy. It can broadcast invalidations to the other sharers and wait for their acknowledgements. It has one transaction slot for work that takes time, such as an invalidation round or a forward. The line held by that slot is busy. Any request to the busy line is refused with a retry reply (NACK). Any request that would need the slot while it is in use is refused in the same way. Requests to other lines that can be answered at once are still served.

Top module: `home_dir_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every directory entry is uncached and no output valid is asserted.
- R2: A read (req_type 0) of an uncached or shared-clean line returns rsp_kind 0 (data from memory) to the requester one cycle later. The line becomes shared-clean (state 2'b01) and the requester is added to its sharer vector.
- R3: A read of a dirty line (state 2'b10) returns rsp_kind 1 (forward). rsp_node is the owner and rsp_peer is the requester. The line becomes busy.
- R4: When wb_done ends a forwarded read, the line becomes shared-clean. Its sharers are exactly the requester and the old owner.
- R5: An exclusive request (req_type 1) to a shared line that has other sharers asserts inv_valid one cycle later. inv_mask is the sharer vector with the requester's bit cleared. No response is sent at that point.
- R6: The exclusive grant (gnt_valid, gnt_node, gnt_line) comes out one cycle after the last expected inv_ack. The line is then dirty at the requester and its sharer vector is empty. An inv_ack with no invalidation round open has no effect.
- R7: An exclusive request is granted at once with rsp_kind 2 in three cases: the line is uncached, the requester is the only sharer, or the requester already owns the line. No invalidation is sent. The line becomes dirty at the requester.
- R8: A modify notice (req_type 2) from the only sharer, or from the owner, returns rsp_kind 4 and the line becomes dirty at that node. Any other modify notice returns NACK (rsp_kind 3).
- R9: A request gets NACK and leaves the directory unchanged if its line is busy, or if it needs the transaction slot while the slot is in use.
- R10: A request from a node number of NODES or above, or with req_type 3, gets NACK.
- R11: An exclusive request to a line that is dirty at another node is forwarded to the owner with rsp_kind 1. When wb_done arrives, the line becomes dirty at the requester. A wb_done with no forward open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 2 | 0 read, 1 exclusive, 2 modify notice, 3 reserved |
| req_node | input | NODE_W | Requesting node |
| req_line | input | LINE_W | Line index |
| inv_ack | input | 1 | One invalidation acknowledgement |
| wb_done | input | 1 | Owner has written back for the open forward |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 3 | 0 memory data, 1 forward, 2 grant, 3 NACK, 4 notice accepted |
| rsp_node | output | NODE_W | Destination node (the owner for a forward) |
| rsp_peer | output | NODE_W | Requesting node |
| rsp_line | output | LINE_W | Line index |
| inv_valid | output | 1 | Invalidation broadcast valid |
| inv_mask | output | NODES | Nodes to invalidate |
| inv_line | output | LINE_W | Line to invalidate |
| gnt_valid | output | 1 | Deferred exclusive grant valid |
| gnt_node | output | NODE_W | Node receiving the grant |
| gnt_line | output | LINE_W | Granted line |

## Verification
The bench runs a reference model alongside the design and aims at the races. It sends requests to the line of an open invalidation round, which must get NACK; a design that let one through would hand out two writable copies. It sends an exclusive request from a node that is itself in the sharer vector; a design that did not mask that node would invalidate the requester or wait for an acknowledgement that never comes, and the grant would hang. It also sends stray acknowledgements and write-backs; a design that counted them would grant too early or free the slot while a forward is still open. Finally it checks the sharer set after a forwarded read, by issuing a later exclusive request whose invalidation mask must name both the old owner and the reader.

// File: rtl/coh_pkg.sv
// Shared encodings for the home-node directory controller.
// Assumes: all modules of the controller import this package.
package coh_pkg;
    typedef enum logic [1:0] {
        LN_UNCACHED = 2'b00,
        LN_SHARED   = 2'b01,
        LN_DIRTY    = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        RQ_READ   = 2'd0,
        RQ_EXCL   = 2'd1,
        RQ_NOTIFY = 2'd2,
        RQ_RSVD   = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        RS_MEMDATA   = 3'd0,
        RS_FORWARD   = 3'd1,
        RS_GRANT     = 3'd2,
        RS_NACK      = 3'd3,
        RS_NOTIFY_OK = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        TX_INV    = 2'd0,
        TX_FWD_RD = 2'd1,
        TX_FWD_EX = 2'd2
    } txn_e;
endpackage

// File: rtl/home_dir_store.sv
// Directory storage: per-line state, sharer vector and owner.
// One combinational read port and two write ports. Port A is written by
// the request path and port B by the completion path.
// Assumes: both ports never write the same line in one cycle, because the
// busy line refuses requests.
module home_dir_store
    import coh_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int NODES  = 16,
    parameter int NODE_W = 8,
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output line_st_e          rd_st,
    output logic [NODES-1:0]  rd_sh,
    output logic [NODE_W-1:0] rd_own,
    input  logic              wa_en,
    input  logic [LINE_W-1:0] wa_line,
    input  line_st_e          wa_st,
    input  logic [NODES-1:0]  wa_sh,
    input  logic [NODE_W-1:0] wa_own,
    input  logic              wb_en,
    input  logic [LINE_W-1:0] wb_line,
    input  line_st_e          wb_st,
    input  logic [NODES-1:0]  wb_sh,
    input  logic [NODE_W-1:0] wb_own
);
    line_st_e          st_q  [LINES];
    logic [NODES-1:0]  sh_q  [LINES];
    logic [NODE_W-1:0] own_q [LINES];

    // Read the addressed entry.
    assign rd_st  = st_q[rd_line];
    assign rd_sh  = sh_q[rd_line];
    assign rd_own = own_q[rd_line];

    // Clear all entries on reset, otherwise apply both write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LN_UNCACHED;
                sh_q[i]  <= '0;
                own_q[i] <= '0;
            end
        end else begin
            if (wa_en) begin
                st_q[wa_line]  <= wa_st;
                sh_q[wa_line]  <= wa_sh;
                own_q[wa_line] <= wa_own;
            end
            if (wb_en) begin
                st_q[wb_line]  <= wb_st;
                sh_q[wb_line]  <= wb_sh;
                own_q[wb_line] <= wb_own;
            end
        end
    end

    // R9: a busy line never takes a request-path write in the same cycle as its completion.
    p_no_port_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en && wb_en && wa_line == wb_line));
endmodule

// File: rtl/home_dir_txn.sv
// Transaction slot: holds the one line that has an invalidation round or a
// forward open. Counts acknowledgements down and raises done for one cycle
// on the last acknowledgement or on the write-back.
// Assumes: start is raised only while the slot is free.
module home_dir_txn
    import coh_pkg::*;
#(
    parameter int NODE_W = 8,
    parameter int LINE_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  txn_e              start_kind,
    input  logic [LINE_W-1:0] start_line,
    input  logic [NODE_W-1:0] start_req,
    input  logic [NODE_W-1:0] start_own,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              ack,
    input  logic              wb,
    output logic              busy,
    output logic [LINE_W-1:0] cur_line,
    output logic              done,
    output txn_e              done_kind,
    output logic [NODE_W-1:0] done_req,
    output logic [NODE_W-1:0] done_own
);
    txn_e              kind_q;
    logic [CNT_W-1:0]  cnt_q;

    // Completion: last acknowledgement of a round, or the write-back of a forward.
    assign done = busy && ((kind_q == TX_INV) ? (ack && cnt_q == CNT_W'(1)) : wb);
    assign done_kind = kind_q;

    // Open, count down and close the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            kind_q   <= TX_INV;
            cnt_q    <= '0;
            cur_line <= '0;
            done_req <= '0;
            done_own <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            kind_q   <= start_kind;
            cnt_q    <= start_cnt;
            cur_line <= start_line;
            done_req <= start_req;
            done_own <= start_own;
        end else if (busy && kind_q == TX_INV && ack) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R9: the slot is never opened twice.
    p_start_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R5: an open invalidation round always expects at least one acknowledgement.
    p_round_has_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == TX_INV) |-> cnt_q != '0);
endmodule

// File: rtl/home_dir_ctrl.sv
// Home-node directory coherence controller (top).
// Decodes one request per cycle against the directory entry. It answers
// from memory, forwards to the owner, grants at once, or opens an
// invalidation round in the transaction slot. A completion and a request
// may occur in the same cycle. Responses are registered, so they appear
// one cycle after the event that causes them.
// Assumes: acknowledgements and write-backs refer to the open transaction.
module home_dir_ctrl
    import coh_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int NODE_W = 8,
    parameter int LINES  = 16,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    input  logic              inv_ack,
    input  logic              wb_done,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [NODE_W-1:0] rsp_node,
    output logic [NODE_W-1:0] rsp_peer,
    output logic [LINE_W-1:0] rsp_line,
    output logic              inv_valid,
    output logic [NODES-1:0]  inv_mask,
    output logic [LINE_W-1:0] inv_line,
    output logic              gnt_valid,
    output logic [NODE_W-1:0] gnt_node,
    output logic [LINE_W-1:0] gnt_line
);
    localparam logic [NODES-1:0] ONE_BIT = {{(NODES-1){1'b0}}, 1'b1};

    line_st_e          rd_st, wa_st, wb_st;
    logic [NODES-1:0]  rd_sh, wa_sh, wb_sh, req_bit, others;
    logic [NODE_W-1:0] rd_own, wa_own, wb_own;
    logic              wa_en;
    logic              busy, done, start, node_ok, line_busy;
    logic [LINE_W-1:0] cur_line;
    txn_e              done_kind, start_kind;
    logic [NODE_W-1:0] done_req, done_own, d_dst;
    logic [CNT_W-1:0]  inv_cnt;
    logic              d_rsp_v, d_inv_v;
    rsp_e              d_kind;
    req_e              rtype;

    assign rtype     = req_e'(req_type);
    assign node_ok   = 32'(req_node) < NODES;
    assign req_bit   = node_ok ? (ONE_BIT << req_node) : '0;
    assign others    = rd_sh & ~req_bit;
    assign line_busy = busy && cur_line == req_line;

    home_dir_store #(.LINES(LINES), .NODES(NODES), .NODE_W(NODE_W), .LINE_W(LINE_W)) u_store (
        .clk, .rst_n, .rd_line(req_line), .rd_st, .rd_sh, .rd_own,
        .wa_en, .wa_line(req_line), .wa_st, .wa_sh, .wa_own,
        .wb_en(done), .wb_line(cur_line), .wb_st, .wb_sh, .wb_own
    );

    home_dir_txn #(.NODE_W(NODE_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_txn (
        .clk, .rst_n, .start, .start_kind, .start_line(req_line), .start_req(req_node),
        .start_own(rd_own), .start_cnt(inv_cnt), .ack(inv_ack), .wb(wb_done),
        .busy, .cur_line, .done, .done_kind, .done_req, .done_own
    );

    // Count the sharers that must acknowledge an invalidation.
    always_comb begin
        inv_cnt = '0;
        for (int i = 0; i < NODES; i++) inv_cnt = inv_cnt + CNT_W'(others[i]);
    end

    // Decide the action for the incoming request.
    always_comb begin
        d_rsp_v    = 1'b0;
        d_kind     = RS_NACK;
        d_dst      = req_node;
        d_inv_v    = 1'b0;
        wa_en      = 1'b0;
        wa_st      = rd_st;
        wa_sh      = rd_sh;
        wa_own     = rd_own;
        start      = 1'b0;
        start_kind = TX_INV;
        if (req_valid) begin
            d_rsp_v = 1'b1;
            if (node_ok && rtype != RQ_RSVD && !line_busy) begin
                case (rtype)
                    RQ_READ: begin
                        if (rd_st == LN_DIRTY) begin
                            if (!busy) begin
                                d_kind     = RS_FORWARD;
                                d_dst      = rd_own;
                                start      = 1'b1;
                                start_kind = TX_FWD_RD;
                            end
                        end else begin
                            d_kind = RS_MEMDATA;
                            wa_en  = 1'b1;
                            wa_st  = LN_SHARED;
                            wa_sh  = rd_sh | req_bit;
                        end
                    end
                    RQ_EXCL: begin
                        if (rd_st == LN_UNCACHED || (rd_st == LN_SHARED && others == '0) ||
                            (rd_st == LN_DIRTY && rd_own == req_node)) begin
                            d_kind = RS_GRANT;
                            wa_en  = 1'b1;
                            wa_st  = LN_DIRTY;
                            wa_sh  = '0;
                            wa_own = req_node;
                        end else if (!busy) begin
                            start = 1'b1;
                            if (rd_st == LN_SHARED) begin
                                d_rsp_v    = 1'b0;
                                d_inv_v    = 1'b1;
                                start_kind = TX_INV;
                            end else begin
                                d_kind     = RS_FORWARD;
                                d_dst      = rd_own;
                                start_kind = TX_FWD_EX;
                            end
                        end
                    end
                    RQ_NOTIFY: begin
                        if ((rd_st == LN_SHARED && rd_sh == req_bit) ||
                            (rd_st == LN_DIRTY && rd_own == req_node)) begin
                            d_kind = RS_NOTIFY_OK;
                            wa_en  = 1'b1;
                            wa_st  = LN_DIRTY;
                            wa_sh  = '0;
                            wa_own = req_node;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Entry written when the open transaction completes.
    always_comb begin
        wb_st  = LN_DIRTY;
        wb_sh  = '0;
        wb_own = done_req;
        if (done_kind == TX_FWD_RD) begin
            wb_st  = LN_SHARED;
            wb_sh  = (ONE_BIT << done_req) | (ONE_BIT << done_own);
            wb_own = done_own;
        end
    end

    // Register all outward messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= '0;
            rsp_node  <= '0;
            rsp_peer  <= '0;
            rsp_line  <= '0;
            inv_valid <= 1'b0;
            inv_mask  <= '0;
            inv_line  <= '0;
            gnt_valid <= 1'b0;
            gnt_node  <= '0;
            gnt_line  <= '0;
        end else begin
            rsp_valid <= d_rsp_v;
            rsp_kind  <= d_kind;
            rsp_node  <= d_dst;
            rsp_peer  <= req_node;
            rsp_line  <= req_line;
            inv_valid <= d_inv_v;
            inv_mask  <= others;
            inv_line  <= req_line;
            gnt_valid <= done && done_kind == TX_INV;
            gnt_node  <= done_req;
            gnt_line  <= cur_line;
        end
    end

    // R2: a response only follows a request.
    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R3: a forward leaves the slot occupied.
    p_fwd_holds_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'(RS_FORWARD)) |-> busy);
    // R5: an invalidation always names at least one node.
    p_inv_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_mask != '0);
    // R6: a deferred grant follows an acknowledgement.
    p_gnt_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(inv_ack));
endmodule

// File: tb/home_dir_ctrl_tb.sv
// Self-checking bench: a reference model in bench functions, with directed
// corner cases and then seeded random traffic.
module home_dir_ctrl_tb;
    localparam int NODES = 16;
    localparam int LINES = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_type = '0;
    logic [7:0]  req_node = '0;
    logic [3:0]  req_line = '0;
    logic        inv_ack = 1'b0;
    logic        wb_done = 1'b0;
    logic        rsp_valid, inv_valid, gnt_valid;
    logic [2:0]  rsp_kind;
    logic [7:0]  rsp_node, rsp_peer, gnt_node;
    logic [3:0]  rsp_line, inv_line, gnt_line;
    logic [15:0] inv_mask;

    home_dir_ctrl #(.NODES(NODES), .NODE_W(8), .LINES(LINES)) u_dut (
        .clk, .rst_n, .req_valid, .req_type, .req_node, .req_line, .inv_ack, .wb_done,
        .rsp_valid, .rsp_kind, .rsp_node, .rsp_peer, .rsp_line,
        .inv_valid, .inv_mask, .inv_line, .gnt_valid, .gnt_node, .gnt_line
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Reference model state.
    int          m_st  [LINES];
    logic [15:0] m_sh  [LINES];
    int          m_own [LINES];
    bit m_busy = 1'b0;
    int m_bline, m_bkind, m_breq, m_bown, m_cnt;

    // Expected outputs for the current step.
    bit e_rsp_v, e_inv_v, e_gnt_v;
    int e_kind, e_dst, e_peer, e_line, e_gnt_node, e_gnt_line;
    logic [15:0] e_mask;
    string e_tag;

    function automatic logic [15:0] nbit(int n);
        return (n < NODES) ? (16'd1 << n) : 16'd0;
    endfunction

    function automatic int popc(logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic void model_req(int t, int n, int l);
        logic [15:0] oth;
        e_rsp_v = 1; e_kind = 3; e_dst = n; e_peer = n; e_line = l;
        if (t == 3 || n >= NODES) begin e_tag = "R10"; return; end
        if (m_busy && m_bline == l) begin e_tag = "R9"; return; end
        oth = m_sh[l] & ~nbit(n);
        if (t == 0) begin
            if (m_st[l] == 2) begin
                if (m_busy) begin e_tag = "R9"; return; end
                e_kind = 1; e_dst = m_own[l]; e_tag = "R3";
                m_busy = 1; m_bline = l; m_bkind = 1; m_breq = n; m_bown = m_own[l];
            end else begin
                e_kind = 0; e_tag = "R2"; m_st[l] = 1; m_sh[l] = m_sh[l] | nbit(n);
            end
        end else if (t == 1) begin
            if (m_st[l] == 0 || (m_st[l] == 1 && oth == 0) || (m_st[l] == 2 && m_own[l] == n)) begin
                e_kind = 2; e_tag = "R7"; m_st[l] = 2; m_sh[l] = 0; m_own[l] = n;
            end else if (m_busy) begin
                e_tag = "R9";
            end else if (m_st[l] == 1) begin
                e_rsp_v = 0; e_inv_v = 1; e_mask = oth; e_tag = "R5";
                m_busy = 1; m_bline = l; m_bkind = 0; m_breq = n; m_cnt = popc(oth);
            end else begin
                e_kind = 1; e_dst = m_own[l]; e_tag = "R11";
                m_busy = 1; m_bline = l; m_bkind = 2; m_breq = n; m_bown = m_own[l];
            end
        end else begin
            e_tag = "R8";
            if ((m_st[l] == 1 && m_sh[l] == nbit(n)) || (m_st[l] == 2 && m_own[l] == n)) begin
                e_kind = 4; m_st[l] = 2; m_sh[l] = 0; m_own[l] = n;
            end
        end
    endfunction

    function automatic void model_ack();
        e_tag = "R6";
        if (m_busy && m_bkind == 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                e_gnt_v = 1; e_gnt_node = m_breq; e_gnt_line = m_bline;
                m_st[m_bline] = 2; m_sh[m_bline] = 0; m_own[m_bline] = m_breq; m_busy = 0;
            end
        end
    endfunction

    function automatic void model_wb();
        e_tag = "R4";
        if (m_busy && m_bkind != 0) begin
            if (m_bkind == 1) begin
                m_st[m_bline] = 1; m_sh[m_bline] = nbit(m_breq) | nbit(m_bown);
            end else begin
                e_tag = "R11";
                m_st[m_bline] = 2; m_sh[m_bline] = 0; m_own[m_bline] = m_breq;
            end
            m_busy = 0;
        end
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [31:0] ar, er, ai, ei, ag, eg;
        ar = rsp_valid ? {8'd0, 1'b1, rsp_kind, rsp_node, rsp_peer, rsp_line} : 32'd0;
        er = e_rsp_v ? {8'd0, 1'b1, 3'(e_kind), 8'(e_dst), 8'(e_peer), 4'(e_line)} : 32'd0;
        ai = inv_valid ? {11'd0, 1'b1, inv_mask, inv_line} : 32'd0;
        ei = e_inv_v ? {11'd0, 1'b1, e_mask, 4'(e_line)} : 32'd0;
        ag = gnt_valid ? {19'd0, 1'b1, gnt_node, gnt_line} : 32'd0;
        eg = e_gnt_v ? {19'd0, 1'b1, 8'(e_gnt_node), 4'(e_gnt_line)} : 32'd0;
        chk(ar == er, e_tag, "response", ar, er);
        chk(ai == ei, "R5", "invalidation", ai, ei);
        chk(ag == eg, "R6", "grant", ag, eg);
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(bit rv, int t, int n, int l, bit ak, bit wb);
        e_rsp_v = 0; e_inv_v = 0; e_gnt_v = 0; e_mask = 0; e_tag = "R1";
        if (rv) model_req(t, n, l);
        if (ak) model_ack();
        if (wb) model_wb();
        req_valid = rv; req_type = 2'(t); req_node = 8'(n); req_line = 4'(l);
        inv_ack = ak; wb_done = wb;
        @(negedge clk);
        req_valid = 0; inv_ack = 0; wb_done = 0;
        check_outputs();
    endtask

    task automatic rq(int t, int n, int l); step(1, t, n, l, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_sh[i] = 0; m_own[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        chk(!rsp_valid && !inv_valid && !gnt_valid, "R1", "idle after reset",
            {rsp_valid, inv_valid, gnt_valid}, 0);
        // R1: a fresh line is uncached, so an exclusive request is granted at once.
        rq(1, 4, 9);
        // R2 and R5: two readers, then an exclusive request from a third node.
        rq(0, 1, 0); rq(0, 2, 0); rq(1, 3, 0);
        rq(0, 4, 0);                    // R9: busy line
        rq(1, 5, 7);                    // R7: other line, immediate grant
        rq(0, 6, 9);                    // R9: line 9 is dirty and the slot is full
        step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);   // R6: grant on the last ack
        step(0, 0, 0, 0, 1, 0);         // R6: stray ack has no effect
        rq(0, 5, 0);                    // R3: forward to node 3
        step(0, 0, 0, 0, 1, 0);         // R6: ack during a forward is ignored
        step(0, 0, 0, 0, 0, 1);         // R4: write-back
        rq(0, 6, 0);                    // R2: served from memory
        rq(1, 7, 0);                    // R4: mask must be nodes 3, 5, 6
        step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
        rq(2, 7, 0);                    // R8: owner notice
        rq(2, 1, 1);                    // R8: uncached notice refused
        rq(0, 1, 1); rq(2, 1, 1);       // R8: sole sharer notice
        rq(1, 2, 1);                    // R11: forward for ownership
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);         // R11: stray write-back has no effect
        rq(0, 3, 1);                    // R11: now owned by node 2
        step(0, 0, 0, 0, 0, 1);
        rq(1, 20, 2); rq(3, 1, 2);      // R10
        rq(0, 8, 2); rq(1, 8, 2);       // R7: sole sharer upgrade
        rq(0, 9, 3); rq(1, 9, 3);       // R7
        void'($urandom(32'd4242));
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom % 10);
            if (r < 6) rq(int'($urandom % 4), int'($urandom % 18), int'($urandom % 4));
            else if (r < 8) step(0, 0, 0, 0, 1, 0);
            else if (r < 9) step(0, 0, 0, 0, 0, 1);
            else step(0, 0, 0, 0, 0, 0);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule